// File: doc/BRIEF.md
# Preview Stream Decimator

This block thins a received image stream for a low-bandwidth preview channel. Pixels arrive one per valid beat, with flags for the first beat of a frame, the first beat of a line and the last beat of a line. Three skip counts set how many frames, lines and pixels are dropped between kept ones. The kept samples leave on a preview port with their frame and line markers rebuilt, and dropped beats show as cycles with valid low.

A second output carries a registered copy of every input beat to the logging path. Preview settings never affect that copy.

A format select sets the unit of skipping. For plain data the unit is one sample. For 4:2:2 chroma-subsampled data the pixel unit is a pair of pixels. For 4:2:0 data the unit is a pair of pixels and also a pair of lines. The format and the skip counts are captured on the frame-start beat, so the pattern stays fixed for the whole frame.

Top module: `preview_decimator`

## Requirements
- R1: The log outputs are the input valid, data and flags registered once. The start and end flags are gated by valid. Format and skip settings have no effect on them.
- R2: A kept beat appears on the preview port one cycle after its input beat, with the same data and `prev_valid_o` high. A dropped beat gives `prev_valid_o` low in that cycle.
- R3: With frame skip N, N frames are dropped after each kept frame. The first frame after reset is kept. Beats that arrive before the first frame start are never forwarded.
- R4: With line skip N, N line units are dropped after each kept one. The line count restarts at every frame start, so the first line of each frame is kept.
- R5: With pixel skip N, N pixel units are dropped after each kept one. The pixel count restarts at every line start, so the first beat of each kept line is kept.
- R6: Format codes on `fmt_i` are as follows. 0 and 3 use single-sample units. 1 uses pixel pairs, so a count of 1 keeps 2 and drops 2, and a count of 2 keeps 2 and drops 4. 2 uses pixel pairs and line pairs.
- R7: When all three skip counts are zero, every beat of every frame is forwarded.
- R8: Format and skip inputs are sampled only on a valid beat that carries the frame-start flag. Changes at any other time have no effect until the next frame start.
- R9: `prev_sof_o` and `prev_sol_o` mark the first forwarded beat of a kept frame and of a kept line. `prev_sof_o` always comes together with `prev_sol_o`. `prev_eol_o` pulses one cycle after the end-of-line beat of a kept line, even when that beat's pixel is dropped.
- R10: Cycles with `in_valid_i` low advance no counter and forward nothing.
- R11: A frame-start beat also starts a line, even when its line-start flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_sof_i | input | 1 | First beat of frame |
| in_sol_i | input | 1 | First beat of line |
| in_eol_i | input | 1 | Last beat of line |
| in_data_i | input | DW | Pixel sample |
| fmt_i | input | 2 | Skip unit select (R6) |
| frame_skip_i | input | CW | Frames dropped between kept frames |
| line_skip_i | input | CW | Line units dropped between kept lines |
| pixel_skip_i | input | CW | Pixel units dropped between kept pixels |
| log_valid_o | output | 1 | Logged beat valid |
| log_sof_o | output | 1 | Logged frame start |
| log_sol_o | output | 1 | Logged line start |
| log_eol_o | output | 1 | Logged line end |
| log_data_o | output | DW | Logged sample |
| prev_valid_o | output | 1 | Preview beat valid |
| prev_sof_o | output | 1 | Preview frame start |
| prev_sol_o | output | 1 | Preview line start |
| prev_eol_o | output | 1 | Preview line end |
| prev_data_o | output | DW | Preview sample |

## Verification
The bench uses pair formats with counts of 1 and 2. A design that skipped single samples there would keep one pixel where two were expected and break the pair alignment.

Line pairs for the 4:2:0 format are checked across frame boundaries. A line counter that did not restart at frame start would shift which lines survive in the next frame.

The bench also changes the settings in the middle of a frame. A design that sampled them at any time other than frame start would change the pattern partway through the frame.

Other stimuli cover:
- beats sent before the first frame start;
- a frame-start beat whose line-start flag is low;
- idle gaps inside lines, which would shift the pattern if they advanced a counter;
- end-of-line beats whose own pixel is dropped, where the end marker must still appear.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    FMT_RAW    = 2'd0,
    FMT_YUV422 = 2'd1,
    FMT_YUV420 = 2'd2,
    FMT_ALT    = 2'd3
  } fmt_e;

  function automatic logic pix_pair(fmt_e f);
    return (f == FMT_YUV422) || (f == FMT_YUV420);
  endfunction

  function automatic logic line_pair(fmt_e f);
    return f == FMT_YUV420;
  endfunction
endpackage

// File: rtl/pd_phase.sv
// Keep/drop sequencer: after a kept unit, skip_i units are dropped.
// A unit is one or two steps (pair_i). restart_i forces a kept unit.
module pd_phase #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          restart_i,
  input  logic          pair_i,
  input  logic [CW-1:0] skip_i,
  output logic          keep_o
);
  logic          sub_q;
  logic          unit_keep_q;
  logic [CW-1:0] drop_q;
  logic          new_unit;

  assign new_unit = restart_i | ~sub_q;
  assign keep_o   = new_unit ? (restart_i | (drop_q >= skip_i)) : unit_keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q       <= 1'b0;
      unit_keep_q <= 1'b0;
      drop_q      <= '1;  // first unit after reset is kept
    end else if (step_i) begin
      if (new_unit) begin
        unit_keep_q <= keep_o;
        drop_q      <= keep_o ? '0 : drop_q + 1'b1;
        sub_q       <= pair_i;
      end else begin
        sub_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pd_log_tap.sv
module pd_log_tap #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sof_i,
  input  logic          sol_i,
  input  logic          eol_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic          sof_o,
  output logic          sol_o,
  output logic          eol_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      sol_o   <= 1'b0;
      eol_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      sof_o   <= valid_i & sof_i;
      sol_o   <= valid_i & sol_i;
      eol_o   <= valid_i & eol_i;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/preview_decimator.sv
module preview_decimator
  import pd_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_sof_i,
  input  logic          in_sol_i,
  input  logic          in_eol_i,
  input  logic [DW-1:0] in_data_i,
  input  logic [1:0]    fmt_i,
  input  logic [CW-1:0] frame_skip_i,
  input  logic [CW-1:0] line_skip_i,
  input  logic [CW-1:0] pixel_skip_i,
  output logic          log_valid_o,
  output logic          log_sof_o,
  output logic          log_sol_o,
  output logic          log_eol_o,
  output logic [DW-1:0] log_data_o,
  output logic          prev_valid_o,
  output logic          prev_sof_o,
  output logic          prev_sol_o,
  output logic          prev_eol_o,
  output logic [DW-1:0] prev_data_o
);
  typedef struct packed {
    fmt_e          fmt;
    logic [CW-1:0] fskip;
    logic [CW-1:0] lskip;
    logic [CW-1:0] pskip;
  } cfg_t;

  cfg_t cfg_q, cfg_in, cfg_cur;
  logic beat, fs_beat, ls_beat;
  logic frame_hit, line_hit, pix_hit;
  logic frame_keep_q, line_keep_q, frame_keep, line_keep, fwd;

  assign beat    = in_valid_i;
  assign fs_beat = beat & in_sof_i;
  assign ls_beat = beat & (in_sol_i | in_sof_i);

  always_comb begin
    cfg_in.fmt   = fmt_e'(fmt_i);
    cfg_in.fskip = frame_skip_i;
    cfg_in.lskip = line_skip_i;
    cfg_in.pskip = pixel_skip_i;
    cfg_cur      = fs_beat ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (fs_beat) cfg_q <= cfg_in;
  end

  pd_phase #(.CW(CW)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(fs_beat), .restart_i(1'b0),
    .pair_i(1'b0), .skip_i(cfg_cur.fskip), .keep_o(frame_hit)
  );

  pd_phase #(.CW(CW)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(ls_beat), .restart_i(fs_beat),
    .pair_i(line_pair(cfg_cur.fmt)), .skip_i(cfg_cur.lskip), .keep_o(line_hit)
  );

  pd_phase #(.CW(CW)) u_pix (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(beat), .restart_i(ls_beat),
    .pair_i(pix_pair(cfg_cur.fmt)), .skip_i(cfg_cur.pskip), .keep_o(pix_hit)
  );

  assign frame_keep = fs_beat ? frame_hit : frame_keep_q;
  assign line_keep  = ls_beat ? line_hit : line_keep_q;
  assign fwd        = beat & frame_keep & line_keep & pix_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_keep_q <= 1'b0;
      line_keep_q  <= 1'b0;
      prev_valid_o <= 1'b0;
      prev_sof_o   <= 1'b0;
      prev_sol_o   <= 1'b0;
      prev_eol_o   <= 1'b0;
      prev_data_o  <= '0;
    end else begin
      if (fs_beat) frame_keep_q <= frame_hit;
      if (ls_beat) line_keep_q  <= line_hit;
      prev_valid_o <= fwd;
      prev_sof_o   <= fwd & in_sof_i;
      prev_sol_o   <= fwd & (in_sol_i | in_sof_i);
      prev_eol_o   <= beat & in_eol_i & frame_keep & line_keep;
      if (fwd) prev_data_o <= in_data_i;
    end
  end

  pd_log_tap #(.DW(DW)) u_log (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(in_valid_i), .sof_i(in_sof_i),
    .sol_i(in_sol_i), .eol_i(in_eol_i), .data_i(in_data_i),
    .valid_o(log_valid_o), .sof_o(log_sof_o), .sol_o(log_sol_o),
    .eol_o(log_eol_o), .data_o(log_data_o)
  );
endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_sof_i,
  input logic            in_sol_i,
  input logic [DW-1:0]   in_data_i,
  input logic            log_valid_o,
  input logic [DW-1:0]   log_data_o,
  input logic            prev_valid_o,
  input logic            prev_sof_o,
  input logic            prev_sol_o,
  input logic [DW-1:0]   prev_data_o,
  input logic [3*CW+1:0] cfg_i
);
  a_r1_log_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> log_valid_o && (log_data_o == $past(in_data_i)));

  a_r1_log_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !log_valid_o);

  a_r2_prev_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_valid_o |-> $past(in_valid_i) && (prev_data_o == $past(in_data_i)));

  a_r9_sof_with_sol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_sof_o |-> prev_sol_o && prev_valid_o);

  a_r9_sol_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_sol_o |-> $past(in_sol_i || in_sof_i));

  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_sof_i) |=> $stable(cfg_i));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !prev_valid_o);
endmodule

bind preview_decimator pd_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_sof_i(in_sof_i),
  .in_sol_i(in_sol_i), .in_data_i(in_data_i), .log_valid_o(log_valid_o),
  .log_data_o(log_data_o), .prev_valid_o(prev_valid_o), .prev_sof_o(prev_sof_o),
  .prev_sol_o(prev_sol_o), .prev_data_o(prev_data_o), .cfg_i(cfg_q)
);

// File: tb/sim_preview_decimator.sv
module sim_preview_decimator;
  localparam int DW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid = 0, in_sof = 0, in_sol = 0, in_eol = 0;
  logic [DW-1:0] in_data = '0;
  logic [1:0]    fmt = '0;
  logic [CW-1:0] fskip = '0, lskip = '0, pskip = '0;
  logic          log_valid, log_sof, log_sol, log_eol, prev_valid, prev_sof, prev_sol, prev_eol;
  logic [DW-1:0] log_data, prev_data;

  preview_decimator #(.DW(DW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_sof_i(in_sof),
    .in_sol_i(in_sol), .in_eol_i(in_eol), .in_data_i(in_data), .fmt_i(fmt),
    .frame_skip_i(fskip), .line_skip_i(lskip), .pixel_skip_i(pskip),
    .log_valid_o(log_valid), .log_sof_o(log_sof), .log_sol_o(log_sol),
    .log_eol_o(log_eol), .log_data_o(log_data), .prev_valid_o(prev_valid),
    .prev_sof_o(prev_sof), .prev_sol_o(prev_sol), .prev_eol_o(prev_eol),
    .prev_data_o(prev_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string req = "R2";
  logic [DW-1:0] seq = '0;

  // reference model state
  bit e_lv, e_lsof, e_lsol, e_leol, e_pv, e_psof, e_psol, e_peol;
  logic [DW-1:0] e_ld = '0, e_pd = '0;
  int m_fmt = 0, m_fs = 0, m_ls = 0, m_ps = 0;
  int f_since = 1000, line_idx = 0, pix_idx = 0;
  bit f_keep = 0, l_keep = 0;

  task automatic chk(string r, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R1", "log_valid", DW'(log_valid), DW'(e_lv));
    chk("R1", "log_sof", DW'(log_sof), DW'(e_lsof));
    chk("R1", "log_sol", DW'(log_sol), DW'(e_lsol));
    chk("R1", "log_eol", DW'(log_eol), DW'(e_leol));
    chk("R1", "log_data", log_data, e_ld);
    chk(req, "prev_valid", DW'(prev_valid), DW'(e_pv));
    chk("R9", "prev_sof", DW'(prev_sof), DW'(e_psof));
    chk("R9", "prev_sol", DW'(prev_sol), DW'(e_psol));
    chk("R9", "prev_eol", DW'(prev_eol), DW'(e_peol));
    if (e_pv) chk("R2", "prev_data", prev_data, e_pd);
  endtask

  task automatic drive(bit v, bit sof, bit sol, bit eol, logic [DW-1:0] d);
    bit ls, pk;
    int ul, up;
    @(negedge clk);
    compare();
    in_valid = v; in_sof = sof; in_sol = sol; in_eol = eol; in_data = d;
    e_lv = v; e_lsof = v && sof; e_lsol = v && sol; e_leol = v && eol; e_ld = d;
    e_pv = 0; e_psof = 0; e_psol = 0; e_peol = 0;
    if (v) begin
      ls = sof || sol;
      if (sof) begin
        m_fmt = int'(fmt); m_fs = int'(fskip); m_ls = int'(lskip); m_ps = int'(pskip);
        f_keep = (f_since >= m_fs);
        f_since = f_keep ? 0 : f_since + 1;
        line_idx = 0;
      end else if (ls) begin
        line_idx++;
      end
      if (ls) begin
        ul = (m_fmt == 2) ? 2 : 1;
        l_keep = ((line_idx / ul) % (m_ls + 1)) == 0;
        pix_idx = 0;
      end else begin
        pix_idx++;
      end
      up = (m_fmt == 1 || m_fmt == 2) ? 2 : 1;
      pk = ((pix_idx / up) % (m_ps + 1)) == 0;
      e_pv = f_keep && l_keep && pk;
      e_psof = e_pv && sof;
      e_psol = e_pv && ls;
      e_peol = eol && f_keep && l_keep;
      if (e_pv) e_pd = d;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, seq);
  endtask

  task automatic set_cfg(int f, int fs, int ls, int ps);
    fmt = 2'(f); fskip = CW'(fs); lskip = CW'(ls); pskip = CW'(ps);
  endtask

  task automatic frame(int w, int h, bit gaps, bit poke);
    logic [1:0] s_fmt;
    logic [CW-1:0] s_f, s_l, s_p;
    s_fmt = fmt; s_f = fskip; s_l = lskip; s_p = pskip;
    for (int l = 0; l < h; l++) begin
      for (int p = 0; p < w; p++) begin
        seq++;
        drive(1, l == 0 && p == 0, p == 0, p == w - 1, seq);
        if (gaps && (p % 3 == 1)) idle(1);
      end
      if (poke && l == 0) set_cfg(int'(~s_fmt), int'(~s_f), int'(~s_l), int'(~s_p));
    end
    if (poke) begin fmt = s_fmt; fskip = s_f; lskip = s_l; pskip = s_p; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R2";
    compare();  // reset state: all outputs low
    rst_n = 1'b1;
    idle(2);
    // R3: beats before the first frame start are dropped
    req = "R3";
    for (int p = 0; p < 5; p++) begin seq++; drive(1, 0, p == 0, p == 4, seq); end
    // R7: zero skips forward everything
    req = "R7"; set_cfg(0, 0, 0, 0);
    repeat (2) frame(6, 4, 0, 0);
    // R3: frame skip
    req = "R3"; set_cfg(0, 2, 0, 0);
    repeat (7) frame(4, 2, 0, 0);
    set_cfg(0, 1, 0, 0);
    repeat (4) frame(4, 2, 0, 0);
    // R4: line skip, restarting each frame
    req = "R4"; set_cfg(0, 0, 1, 0);
    repeat (2) frame(3, 7, 0, 0);
    set_cfg(0, 0, 3, 0);
    repeat (2) frame(3, 9, 0, 0);
    // R5: pixel skip
    req = "R5";
    for (int s = 1; s <= 3; s++) begin set_cfg(0, 0, 0, s); frame(13, 3, 0, 0); end
    // R6: pair units
    req = "R6";
    set_cfg(1, 0, 0, 1); frame(12, 3, 0, 0);
    set_cfg(1, 0, 0, 2); frame(13, 3, 0, 0);
    set_cfg(2, 0, 1, 1); repeat (2) frame(10, 9, 0, 0);
    set_cfg(2, 0, 2, 0); frame(4, 13, 0, 0);
    set_cfg(3, 0, 1, 2); frame(9, 5, 0, 0);
    // R10: idle gaps inside lines
    req = "R10"; set_cfg(2, 1, 1, 2);
    repeat (3) frame(11, 6, 1, 0);
    // R8: mid-frame setting changes are ignored
    req = "R8"; set_cfg(1, 0, 1, 1);
    repeat (3) frame(9, 5, 0, 1);
    // R11: frame start without line-start flag
    req = "R11"; set_cfg(0, 0, 1, 1);
    for (int l = 0; l < 3; l++)
      for (int p = 0; p < 5; p++) begin
        seq++;
        drive(1, l == 0 && p == 0, p == 0 && l != 0, p == 4, seq);
      end
    // R9: end marker on a line whose last pixel is dropped
    req = "R9"; set_cfg(0, 0, 0, 1);
    repeat (2) frame(6, 3, 0, 0);
    idle(3);
    @(negedge clk);
    compare();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule